// File: doc/BRIEF.md
# Selectable CPU Clock Generator

This block turns a fast main oscillator and a slow subsystem oscillator into clock enables for a processor core and its peripherals. Every cycle of `clk` is one main-oscillator period. The subsystem oscillator arrives as a one-cycle pulse on `sub_tick`, which is synchronous to `clk`.

A write-only byte register, loaded through `mode_wr`/`mode_wdata`, holds one live bit, bit 0. That bit either routes the oscillator through a fixed divide-by-two scaler or bypasses the scaler. The scaled main clock appears as `periph_en`. A 3-bit rate select then divides that clock by a power of two, or picks half the subsystem rate. The result appears as the single-cycle enable `cpu_en`. A second enable, `instr_en`, marks every second CPU clock, which is the rate of the shortest instruction. `rate_now` reports the rate code currently in force.

Any write to the mode register stalls the main clock path for two oscillator periods, even when the written value is unchanged. This reproduces the clock stretch that such a write causes.

The block is built from three state machines:
- **Stall unit.** It has states `ST_RUN` and `ST_HOLD`. A register write moves it from `ST_RUN` to `ST_HOLD`, or restarts `ST_HOLD`. It returns to `ST_RUN` when the hold count expires.
- **Divider.** It has states `DV_MAIN` and `DV_SUB`. At each period boundary it moves to `DV_SUB` when the newly sampled code is 6, and to `DV_MAIN` otherwise.
- **Scaler phase.** This is a toggle that alternates between an idle phase and a tick phase.

Top module: `cpu_clkgen`

## Requirements
- R1: While `rst_n` is low, `cpu_en`, `instr_en` and `periph_en` are 0 and `rate_now` is 0. The mode register resets to 0x00, which selects the scaler.
- R2: With mode bit 0 = 0 (scaler used), `periph_en` pulses every second cycle. With bit 0 = 1 (scaler bypassed), `periph_en` is high every cycle.
- R3: For rate codes n = 0..5, `cpu_en` pulses once every 2^n `periph_en` pulses. With the scaler used, that is every 2^(n+1) cycles. `rate_now` reads n.
- R4: Rate code 6 makes `cpu_en` pulse on every second `sub_tick` pulse, and `rate_now` reads 6.
- R5: Reserved rate code 7 behaves exactly like code 0, and `rate_now` reads 0.
- R6: A new `rate_sel` value is sampled only at the end of the current CPU period. The pulse that closes the old period keeps its full length, and `rate_now` changes in the same cycle as that pulse.
- R7: Only bit 0 of a mode write has any effect. Bits 7..1 are ignored, so 0xFF acts as 0x01 and 0xFE acts as 0x00.
- R8: A mode write, including one that rewrites the current value, stalls the main path. Take the cycle in which `mode_wr` is high as cycle t. Then `periph_en` (and any main-derived `cpu_en`) is 0 in cycles t+2 and t+3.
- R9: A change of mode bit 0 changes the `periph_en` rate and the main-derived `cpu_en` rate together.
- R10: `instr_en` is high only together with `cpu_en`, on every second `cpu_en` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_tick | input | 1 | One-cycle pulse per subsystem oscillator period |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 8 | Mode byte; bit 0 set bypasses the scaler |
| rate_sel | input | 3 | Rate code: 0..5 main divided by 2^n, 6 subsystem/2, 7 as 0 |
| cpu_en | output | 1 | CPU clock enable |
| instr_en | output | 1 | Enable on every second CPU clock |
| periph_en | output | 1 | Scaled main clock enable for peripherals |
| rate_now | output | 3 | Rate code currently in force |

## Verification
All outputs are registered one stage after the decision that makes them. An enable therefore appears in the cycle after the scaler tick or subsystem pulse that produced it. `rate_now` moves in the same cycle as the pulse that closes a period. The stall is visible as two empty enable cycles, starting two cycles after the write strobe.

The scoreboard compares the spacing between consecutive `cpu_en` pulses, together with `rate_now`. It checks only after several pulses at a new setting, so every compared spacing is a settled period. The only exception is the pulse that the boundary check deliberately targets. The stall and rate checks count enables over fixed windows of negative-edge samples, placed right after the write.

// File: rtl/cpu_clkgen_pkg.sv
package cpu_clkgen_pkg;
    typedef enum logic {
        ST_RUN,
        ST_HOLD
    } stall_st_t;

    typedef enum logic {
        DV_MAIN,
        DV_SUB
    } div_st_t;

    typedef enum logic {
        PH_IDLE,
        PH_TICK
    } pre_ph_t;
endpackage

// File: rtl/cpu_clkgen_stall.sv
module cpu_clkgen_stall
    import cpu_clkgen_pkg::*;
#(
    parameter int MODE_W       = 8,
    parameter int BYPASS_BIT   = 0,
    parameter int STALL_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    output logic              bypass,
    output logic              run
);
    localparam int HC_W = (STALL_CYCLES > 1) ? $clog2(STALL_CYCLES) : 1;
    localparam logic [MODE_W-1:0] LIVE_MASK = MODE_W'(1) << BYPASS_BIT;
    localparam logic [HC_W-1:0] HOLD_LOAD = HC_W'(STALL_CYCLES - 1);

    stall_st_t        state_q, state_d;
    logic [HC_W-1:0]  hold_q;
    logic [MODE_W-1:0] mode_q;

    // Next-state logic of the stall machine.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (mode_wr) state_d = ST_HOLD;
            ST_HOLD: if (!mode_wr && hold_q == '0) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Hold counter and mode byte.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            mode_q <= '0;
        end else begin
            if (mode_wr) begin
                hold_q <= HOLD_LOAD;
                mode_q <= mode_wdata & LIVE_MASK;
            end else if (state_q == ST_HOLD && hold_q != '0) begin
                hold_q <= hold_q - 1'b1;
            end
        end
    end

    // Outputs.
    always_comb begin
        run    = (state_q == ST_RUN);
        bypass = |mode_q;
    end
endmodule

// File: rtl/cpu_clkgen_prescale.sv
module cpu_clkgen_prescale
    import cpu_clkgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic bypass,
    input  logic restart,
    output logic base_tick,
    output logic periph_en
);
    pre_ph_t ph_q, ph_d;

    // Next phase of the divide-by-two scaler.
    always_comb begin
        ph_d = ph_q;
        if (restart) begin
            ph_d = PH_IDLE;
        end else if (run && !bypass) begin
            unique case (ph_q)
                PH_IDLE: ph_d = PH_TICK;
                PH_TICK: ph_d = PH_IDLE;
                default: ph_d = PH_IDLE;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    // Scaled main clock tick.
    always_comb begin
        base_tick = run && (bypass || ph_q == PH_TICK);
    end

    // Registered peripheral enable.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) periph_en <= 1'b0;
        else        periph_en <= base_tick;
    end
endmodule

// File: rtl/cpu_clkgen_divider.sv
module cpu_clkgen_divider
    import cpu_clkgen_pkg::*;
#(
    parameter int DIV_STAGES = 6,
    parameter int SEL_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_tick,
    input  logic             sub_tick,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             cpu_en,
    output logic             instr_en,
    output logic [SEL_W-1:0] rate_now
);
    localparam int CNT_W    = (DIV_STAGES > 1) ? DIV_STAGES - 1 : 1;
    localparam int SUB_CODE = DIV_STAGES;
    localparam logic [SEL_W-1:0] SUB_SEL = SEL_W'(SUB_CODE);

    div_st_t          state_q, state_d;
    logic [CNT_W-1:0] cnt_q, lim;
    logic             sph_q, iph_q;
    logic [SEL_W-1:0] sel_q, sel_norm;
    logic             boundary;

    // Codes above the subsystem code fall back to code 0.
    always_comb begin
        sel_norm = (rate_sel > SUB_SEL) ? '0 : rate_sel;
    end

    // Terminal count for the active main division.
    always_comb begin
        lim = '0;
        for (int i = 0; i < DIV_STAGES; i++) begin
            if (sel_q == SEL_W'(i)) lim = CNT_W'((32'd1 << i) - 32'd1);
        end
    end

    // Period boundary and next state.
    always_comb begin
        boundary = 1'b0;
        unique case (state_q)
            DV_MAIN: boundary = base_tick && (cnt_q == lim);
            DV_SUB:  boundary = sub_tick && sph_q;
            default: boundary = 1'b0;
        endcase
        state_d = state_q;
        if (boundary) state_d = (sel_norm == SUB_SEL) ? DV_SUB : DV_MAIN;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DV_MAIN;
        else        state_q <= state_d;
    end

    // Counters and sampled rate.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sph_q <= 1'b0;
            iph_q <= 1'b0;
            sel_q <= '0;
        end else if (boundary) begin
            cnt_q <= '0;
            sph_q <= 1'b0;
            iph_q <= ~iph_q;
            sel_q <= sel_norm;
        end else begin
            unique case (state_q)
                DV_MAIN: if (base_tick) cnt_q <= cnt_q + 1'b1;
                DV_SUB:  if (sub_tick)  sph_q <= ~sph_q;
                default: ;
            endcase
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_en   <= 1'b0;
            instr_en <= 1'b0;
        end else begin
            cpu_en   <= boundary;
            instr_en <= boundary && iph_q;
        end
    end

    assign rate_now = sel_q;
endmodule

// File: rtl/cpu_clkgen.sv
module cpu_clkgen
#(
    parameter int MODE_W       = 8,
    parameter int SEL_W        = 3,
    parameter int DIV_STAGES   = 6,
    parameter int STALL_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sub_tick,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic [SEL_W-1:0]  rate_sel,
    output logic              cpu_en,
    output logic              instr_en,
    output logic              periph_en,
    output logic [SEL_W-1:0]  rate_now
);
    logic bypass, run, base_tick;

    cpu_clkgen_stall #(
        .MODE_W      (MODE_W),
        .BYPASS_BIT  (0),
        .STALL_CYCLES(STALL_CYCLES)
    ) u_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wr   (mode_wr),
        .mode_wdata(mode_wdata),
        .bypass    (bypass),
        .run       (run)
    );

    cpu_clkgen_prescale u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .bypass   (bypass),
        .restart  (mode_wr),
        .base_tick(base_tick),
        .periph_en(periph_en)
    );

    cpu_clkgen_divider #(
        .DIV_STAGES(DIV_STAGES),
        .SEL_W     (SEL_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_tick(base_tick),
        .sub_tick (sub_tick),
        .rate_sel (rate_sel),
        .cpu_en   (cpu_en),
        .instr_en (instr_en),
        .rate_now (rate_now)
    );
endmodule

// File: rtl/cpu_clkgen_chk.sv
module cpu_clkgen_chk #(
    parameter int SEL_W    = 3,
    parameter int SUB_CODE = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_wr,
    input logic             cpu_en,
    input logic             instr_en,
    input logic             periph_en,
    input logic [SEL_W-1:0] rate_now
);
    localparam logic [SEL_W-1:0] SUBV = SEL_W'(SUB_CODE);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!cpu_en && !instr_en && !periph_en && rate_now == '0)
                else $error("outputs active in reset");
        end
    end

    assert_main_cpu_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_en && rate_now != SUBV && $past(rate_now) != SUBV) |-> periph_en);

    assert_no_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rate_now <= SUBV);

    assert_rate_moves_on_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_en |-> $stable(rate_now));

    assert_stall_first_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_wr, 2) |-> !periph_en);

    assert_stall_second_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_wr, 3) |-> !periph_en);

    assert_instr_with_cpu_R10: assert property (@(posedge clk) disable iff (!rst_n)
        instr_en |-> cpu_en);
endmodule

bind cpu_clkgen cpu_clkgen_chk #(
    .SEL_W   (SEL_W),
    .SUB_CODE(DIV_STAGES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_wr  (mode_wr),
    .cpu_en   (cpu_en),
    .instr_en (instr_en),
    .periph_en(periph_en),
    .rate_now (rate_now)
);

// File: tb/cpu_clkgen_tb.sv
`timescale 1ns/1ps
module cpu_clkgen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sub_tick = 1'b0;
    logic       mode_wr = 1'b0;
    logic [7:0] mode_wdata = 8'h00;
    logic [2:0] rate_sel = 3'd0;
    logic       cpu_en, instr_en, periph_en;
    logic [2:0] rate_now;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        int    gap;
        int    rate;
        string tag;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    cpu_clkgen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sub_tick  (sub_tick),
        .mode_wr   (mode_wr),
        .mode_wdata(mode_wdata),
        .rate_sel  (rate_sel),
        .cpu_en    (cpu_en),
        .instr_en  (instr_en),
        .periph_en (periph_en),
        .rate_now  (rate_now)
    );

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    // Subsystem oscillator: one pulse every 8 cycles.
    initial begin
        int sc = 0;
        forever begin
            @(negedge clk);
            sub_tick = (sc == 0);
            sc = (sc + 1) % 8;
        end
    end

    // Monitor: spacing of cpu_en pulses against the scoreboard queue.
    initial begin
        int cyc = 0;
        int last = 0;
        bit have = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n && cpu_en) begin
                if (have && q.size() > 0) begin
                    exp_t e;
                    e = q.pop_front();
                    chk(e.tag, "cpu gap", cyc - last, e.gap);
                    chk(e.tag, "rate_now", int'(rate_now), e.rate);
                end
                last = cyc;
                have = 1;
            end
        end
    end

    task automatic push(int gap, int rate, string tag, int n);
        for (int i = 0; i < n; i++) q.push_back('{gap, rate, tag});
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        #1;
    endtask

    task automatic wait_pulses(int n);
        int k = 0;
        while (k < n) begin
            @(negedge clk);
            if (cpu_en) k++;
        end
        #1;
    endtask

    task automatic set_sel(logic [2:0] v);
        @(negedge clk);
        #1 rate_sel = v;
    endtask

    task automatic wr_mode(logic [7:0] v);
        @(negedge clk);
        #1;
        mode_wr = 1'b1;
        mode_wdata = v;
        @(negedge clk);
        #1 mode_wr = 1'b0;
    endtask

    task automatic count_win(int which, int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            case (which)
                0: c += int'(periph_en);
                1: c += int'(cpu_en);
                default: c += int'(instr_en);
            endcase
        end
        #1;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c, pc, cc, viol;
        // R1: reset state.
        repeat (3) @(negedge clk);
        chk("R1", "cpu_en", int'(cpu_en), 0);
        chk("R1", "instr_en", int'(instr_en), 0);
        chk("R1", "periph_en", int'(periph_en), 0);
        chk("R1", "rate_now", int'(rate_now), 0);
        #1 rst_n = 1'b1;

        // R2/R3: default scaler on, code 0.
        wait_pulses(4);
        push(2, 0, "R3", 4);
        drain();
        count_win(0, 32, c);
        chk("R2", "periph count scaled", c, 16);

        // R3: code 3 with scaler.
        set_sel(3'd3);
        wait_pulses(4);
        push(16, 3, "R3", 3);
        drain();

        // R7: 0xFF acts as bypass.
        wr_mode(8'hFF);
        wait_pulses(4);
        push(8, 3, "R7", 3);
        drain();
        count_win(0, 16, c);
        chk("R2", "periph count bypass", c, 16);

        // R3: code 5, then R6 boundary behaviour.
        set_sel(3'd5);
        wait_pulses(4);
        push(32, 5, "R3", 2);
        drain();
        wait_pulses(1);
        repeat (5) @(negedge clk);
        #1 rate_sel = 3'd0;
        push(32, 0, "R6", 1);
        push(1, 0, "R6", 3);
        drain();

        // R5: reserved code.
        set_sel(3'd7);
        wait_pulses(4);
        push(1, 0, "R5", 3);
        drain();

        // R8: rewrite the same effective value, stall of two cycles.
        set_sel(3'd0);
        wait_pulses(4);
        wr_mode(8'h01);
        pc = 0;
        cc = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            pc += int'(periph_en);
            cc += int'(cpu_en);
        end
        #1;
        chk("R8", "periph after write", pc, 8);
        chk("R8", "cpu after write", cc, 8);

        // R4: subsystem half rate.
        set_sel(3'd6);
        wait_pulses(4);
        push(16, 6, "R4", 3);
        drain();

        // R9: scaler change moves cpu and periph together.
        set_sel(3'd2);
        wait_pulses(4);
        push(4, 2, "R9", 2);
        drain();
        wr_mode(8'hFE);
        wait_pulses(4);
        push(8, 2, "R9", 2);
        drain();
        count_win(0, 32, c);
        chk("R9", "periph count after 0xFE (R7)", c, 16);

        // R10: instruction enable.
        count_win(2, 64, c);
        chk("R10", "instr count", c, 4);
        viol = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (instr_en && !cpu_en) viol++;
        end
        chk("R10", "instr without cpu", viol, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule